// File: doc/BRIEF.md
# Shared-Pin Byte Port with Peripheral Takeover

This block is one byte-wide general-purpose port. It holds a stored output value and a per-bit direction setting. Both sit on a simple byte register bus: an address, a write strobe and write data go in, and combinational read data comes out. Each of the eight pins can be claimed by other logic on the chip, and the port resolves every pin's output value and output enable from that claim. The seven low pins can carry external address or status outputs. The top pin can serve as an input for bus wait or ROM control. Any pin can carry an LCD frontplane signal, and the four low pins can carry LCD backplane signals.

Reading the data register builds each bit from three things: the direction bit, the LCD frontplane claim and the synchronized pin level. An input pin that the LCD frontplane owns reads as a forced 1. The LCD waveform logic and the external bus controller are outside this block. They reach it only through enable and value inputs.

Top module: `gpio_mux_port`

## Requirements
- R1: While `rst` is high and on the first edge after it, the data and direction registers hold 0. Register reads return 0 and, with no peripheral claiming a pin, `pin_oe` is 0.
- R2: A write with `bus_wr` high updates the data register at offset 0x51 or the direction register at offset 0x55 on that clock edge. Reading offset 0x55 returns the direction register.
- R3: For a data-register read (offset 0x51), a bit whose direction bit is 1 returns the stored data bit.
- R4: For a data-register read, a bit whose direction bit is 0 returns 1 when `lcd_en` and that bit of `lcd_fp_en` are both 1.
- R5: For a data-register read, any other input bit returns the pin level delayed by two clock edges through a synchronizer.
- R6: Reads of any offset other than 0x51 and 0x55 return 0, and writes to such offsets change neither register.
- R7: A pin that no peripheral claims drives `pin_o` from the data bit, and `pin_oe` from the direction bit.
- R8: A low pin i (0..6) with `ext_own[i]` set drives `ext_out[i]` with `pin_oe` 1. This holds whatever the direction bit and the LCD inputs are.
- R9: While `ctl_sel` or `rst` is high, pin 7 has `pin_oe` 0, and `bus_ctl_in` shows pin 7's level after two edges.
- R10: A pin claimed by the LCD frontplane (`lcd_en` and `lcd_fp_en[i]`) and not by the external bus drives `lcd_fp_val[i]` with `pin_oe` 1, regardless of direction.
- R11: On pins 0..3, when `lcd_en` and `lcd_bp_en` are set, the backplane value `lcd_bp_val[i]` is driven with `pin_oe` 1, taking precedence over a frontplane claim of the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| ext_own | input | 7 | External bus claims pins 6..0 |
| ext_out | input | 7 | External bus output values |
| ctl_sel | input | 1 | Pin 7 used as bus control input |
| bus_ctl_in | output | 1 | Synchronized pin 7 level |
| lcd_en | input | 1 | LCD module enable |
| lcd_fp_en | input | 8 | Per-pin frontplane enable |
| lcd_fp_val | input | 8 | Frontplane values |
| lcd_bp_en | input | 1 | Backplane enable for pins 3..0 |
| lcd_bp_val | input | 4 | Backplane values |

## Verification
Some properties are checked on every cycle: register clearing at reset, write decode, immunity to unmapped writes, the forced 1 on frontplane-owned inputs, two-edge pin latency, external-bus ownership and the tri-state of pin 7. Other behaviour shows only in the bench scenarios. These include the full read-back merge across mixed direction, LCD and pin patterns, and the GPIO drive of unclaimed pins. They also include LCD frontplane drive and backplane precedence on the low nibble, and the synchronized control input on pin 7.

// File: rtl/gpio_mux_port_pkg.sv
package gpio_mux_port_pkg;

    localparam int PORT_W   = 8;
    localparam int XBUS_W   = 7;
    localparam int BPLANE_W = 4;
    localparam int OFF_W    = 8;

    typedef enum logic [1:0] {
        PIN_GPIO  = 2'd0,
        PIN_LCD   = 2'd1,
        PIN_XBUS  = 2'd2,
        PIN_CTLIN = 2'd3
    } pin_owner_e;

    typedef struct packed {
        logic val;
        logic en;
    } pin_drive_t;

    // The control-input claim wins, then the external bus, then the LCD.
    function automatic pin_owner_e pick_owner(input logic ctl, input logic xbus, input logic lcd);
        if (ctl)       return PIN_CTLIN;
        else if (xbus) return PIN_XBUS;
        else if (lcd)  return PIN_LCD;
        else           return PIN_GPIO;
    endfunction

    function automatic logic readback_bit(input logic dir, input logic dat,
                                          input logic fp_force, input logic pin);
        if (dir)           return dat;
        else if (fp_force) return 1'b1;
        else               return pin;
    endfunction

endpackage

// File: rtl/port_regs.sv
module port_regs
    import gpio_mux_port_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int AW = OFF_W,
    parameter logic [AW-1:0] DATA_OFF = 8'h51,
    parameter logic [AW-1:0] DIR_OFF = 8'h55
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  data_q,
    output logic [W-1:0]  dir_q,
    output logic          hit_data,
    output logic          hit_dir
);
    assign hit_data = (addr == DATA_OFF);
    assign hit_dir  = (addr == DIR_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr) begin
            if (hit_data) data_q <= wdata;
            if (hit_dir)  dir_q  <= wdata;
        end
    end
endmodule

// File: rtl/port_sync.sv
module port_sync
    import gpio_mux_port_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/port_pinmux.sv
module port_pinmux
    import gpio_mux_port_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int XW = XBUS_W,
    parameter int BW = BPLANE_W
) (
    input  logic          rst,
    input  logic [W-1:0]  data_q,
    input  logic [W-1:0]  dir_q,
    input  logic [XW-1:0] ext_own,
    input  logic [XW-1:0] ext_out,
    input  logic          ctl_sel,
    input  logic          lcd_en,
    input  logic [W-1:0]  fp_en,
    input  logic [W-1:0]  fp_val,
    input  logic          bp_en,
    input  logic [BW-1:0] bp_val,
    output logic [W-1:0]  pin_o,
    output logic [W-1:0]  pin_oe
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            logic       x_own, x_val, c_own, b_own, b_val, f_own;
            pin_drive_t drv;

            if (i < XW) begin : g_xbus
                assign x_own = ext_own[i];
                assign x_val = ext_out[i];
            end else begin : g_noxbus
                assign x_own = 1'b0;
                assign x_val = 1'b0;
            end

            if (i == W - 1) begin : g_ctl
                assign c_own = ctl_sel | rst;
            end else begin : g_noctl
                assign c_own = 1'b0;
            end

            if (i < BW) begin : g_bp
                assign b_own = lcd_en & bp_en;
                assign b_val = bp_val[i];
            end else begin : g_nobp
                assign b_own = 1'b0;
                assign b_val = 1'b0;
            end

            assign f_own = lcd_en & fp_en[i];

            always_comb begin
                unique case (pick_owner(c_own, x_own, b_own | f_own))
                    PIN_CTLIN: drv = '{val: 1'b0, en: 1'b0};
                    PIN_XBUS:  drv = '{val: x_val, en: 1'b1};
                    PIN_LCD:   drv = '{val: (b_own ? b_val : fp_val[i]), en: 1'b1};
                    default:   drv = '{val: data_q[i], en: dir_q[i]};
                endcase
            end

            assign pin_o[i]  = drv.val;
            assign pin_oe[i] = drv.en;
        end
    endgenerate
endmodule

// File: rtl/port_readback.sv
module port_readback
    import gpio_mux_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         hit_data,
    input  logic         hit_dir,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic         lcd_en,
    input  logic [W-1:0] fp_en,
    input  logic [W-1:0] pin_s,
    output logic [W-1:0] rdata
);
    logic [W-1:0] merged;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign merged[i] = readback_bit(dir_q[i], data_q[i], lcd_en & fp_en[i], pin_s[i]);
        end
    endgenerate

    always_comb begin
        if (hit_data)     rdata = merged;
        else if (hit_dir) rdata = dir_q;
        else              rdata = '0;
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_port_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int XW = XBUS_W,
    parameter int BW = BPLANE_W,
    parameter int AW = OFF_W,
    parameter int SYNC_STAGES = 2,
    parameter logic [AW-1:0] DATA_OFF = 8'h51,
    parameter logic [AW-1:0] DIR_OFF = 8'h55
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_i,
    output logic [W-1:0]  pin_o,
    output logic [W-1:0]  pin_oe,
    input  logic [XW-1:0] ext_own,
    input  logic [XW-1:0] ext_out,
    input  logic          ctl_sel,
    output logic          bus_ctl_in,
    input  logic          lcd_en,
    input  logic [W-1:0]  lcd_fp_en,
    input  logic [W-1:0]  lcd_fp_val,
    input  logic          lcd_bp_en,
    input  logic [BW-1:0] lcd_bp_val
);
    logic [W-1:0] data_q, dir_q, pin_s;
    logic         hit_data, hit_dir;

    port_regs #(.W(W), .AW(AW), .DATA_OFF(DATA_OFF), .DIR_OFF(DIR_OFF)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q), .hit_data(hit_data), .hit_dir(hit_dir)
    );

    port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
    );

    port_pinmux #(.W(W), .XW(XW), .BW(BW)) u_mux (
        .rst(rst), .data_q(data_q), .dir_q(dir_q), .ext_own(ext_own), .ext_out(ext_out),
        .ctl_sel(ctl_sel), .lcd_en(lcd_en), .fp_en(lcd_fp_en), .fp_val(lcd_fp_val),
        .bp_en(lcd_bp_en), .bp_val(lcd_bp_val), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    port_readback #(.W(W)) u_rb (
        .hit_data(hit_data), .hit_dir(hit_dir), .data_q(data_q), .dir_q(dir_q),
        .lcd_en(lcd_en), .fp_en(lcd_fp_en), .pin_s(pin_s), .rdata(bus_rdata)
    );

    assign bus_ctl_in = pin_s[W-1];
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk
    import gpio_mux_port_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int XW = XBUS_W,
    parameter int AW = OFF_W,
    parameter logic [AW-1:0] DATA_OFF = 8'h51,
    parameter logic [AW-1:0] DIR_OFF = 8'h55
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  bus_rdata,
    input logic [W-1:0]  pin_i,
    input logic [W-1:0]  pin_oe,
    input logic [XW-1:0] ext_own,
    input logic          ctl_sel,
    input logic          lcd_en,
    input logic [W-1:0]  lcd_fp_en,
    input logic [W-1:0]  data_q,
    input logic [W-1:0]  dir_q
);
    logic [1:0] live;

    always_ff @(posedge clk) begin
        if (rst)              live <= '0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (data_q == '0 && dir_q == '0));

    p_write_data_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == DATA_OFF) |=> data_q == $past(bus_wdata));

    p_write_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == DIR_OFF) |=> dir_q == $past(bus_wdata));

    p_fp_forced_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == DATA_OFF && lcd_en) |-> ((bus_rdata & ~dir_q & lcd_fp_en) == (~dir_q & lcd_fp_en)));

    p_pin_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (live >= 2'd2 && bus_addr == DATA_OFF && !lcd_en) |-> (((bus_rdata ^ $past(pin_i, 2)) & ~dir_q) == '0));

    p_unmapped_write_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != DATA_OFF && bus_addr != DIR_OFF) |=> ($stable(data_q) && $stable(dir_q)));

    p_unmapped_read_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != DATA_OFF && bus_addr != DIR_OFF) |-> bus_rdata == '0);

    p_xbus_drive_r8: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe[XW-1:0] & ext_own) == ext_own));

    p_ctl_tristate_r9: assert property (@(posedge clk) (ctl_sel || rst) |-> !pin_oe[W-1]);
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.W(W), .XW(XW), .AW(AW), .DATA_OFF(DATA_OFF), .DIR_OFF(DIR_OFF)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_oe(pin_oe), .ext_own(ext_own),
    .ctl_sel(ctl_sel), .lcd_en(lcd_en), .lcd_fp_en(lcd_fp_en), .data_q(data_q), .dir_q(dir_q)
);

// File: tb/gpio_mux_port_test.sv
module gpio_mux_port_test;
    localparam int CLK_P = 10;
    localparam logic [7:0] A_DAT = 8'h51;
    localparam logic [7:0] A_DIR = 8'h55;
    localparam int NV = 6;
    // {lcd_en(8b), dir, data, fp_en, pin, expected read}
    localparam logic [47:0] VEC [NV] = '{
        {8'h00, 8'hFF, 8'hA5, 8'h00, 8'h00, 8'hA5},
        {8'h00, 8'h00, 8'hFF, 8'hFF, 8'h3C, 8'h3C},
        {8'h01, 8'h00, 8'h00, 8'hF0, 8'h05, 8'hF5},
        {8'h01, 8'h0F, 8'h0A, 8'h30, 8'hC0, 8'hFA},
        {8'h00, 8'h0F, 8'h05, 8'hFF, 8'h90, 8'h95},
        {8'h01, 8'hAA, 8'h88, 8'h55, 8'hFF, 8'hDD}
    };

    logic       clk = 1'b0, rst = 1'b1;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, pin_i = 8'h00;
    logic       bus_wr = 1'b0, ctl_sel = 1'b0, lcd_en = 1'b0, lcd_bp_en = 1'b0;
    logic [6:0] ext_own = '0, ext_out = '0;
    logic [7:0] lcd_fp_en = '0, lcd_fp_val = '0;
    logic [3:0] lcd_bp_val = '0;
    logic [7:0] bus_rdata, pin_o, pin_oe;
    logic       bus_ctl_in;
    int         n_chk = 0, n_err = 0;
    logic       done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    gpio_mux_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .ext_own(ext_own), .ext_out(ext_out), .ctl_sel(ctl_sel), .bus_ctl_in(bus_ctl_in),
        .lcd_en(lcd_en), .lcd_fp_en(lcd_fp_en), .lcd_fp_val(lcd_fp_val),
        .lcd_bp_en(lcd_bp_en), .lcd_bp_val(lcd_bp_val)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        edges(3);
        // R1: reset state
        rd(A_DAT, r); check("R1 data read in reset", r, 8'h00);
        rd(A_DIR, r); check("R1 dir read in reset", r, 8'h00);
        check("R1 pin_oe in reset", pin_oe, 8'h00);
        rst = 1'b0;
        edges(1);
        check("R1 pin_oe after reset", pin_oe, 8'h00);

        // Vector table: R3, R4, R5, R7
        for (int v = 0; v < NV; v++) begin
            lcd_en = VEC[v][40];
            wr(A_DIR, VEC[v][39:32]);
            wr(A_DAT, VEC[v][31:24]);
            lcd_fp_en = VEC[v][23:16];
            pin_i = VEC[v][15:8];
            edges(3);
            rd(A_DAT, r); check("R3/R4/R5 table read", r, VEC[v][7:0]);
            if (!VEC[v][40]) begin
                check("R7 gpio oe", pin_oe, VEC[v][39:32]);
                check("R7 gpio out", pin_o, VEC[v][31:24]);
            end
        end
        lcd_en = 1'b0; lcd_fp_en = '0;

        // R2: direction read back
        wr(A_DIR, 8'h3C);
        rd(A_DIR, r); check("R2 dir readback", r, 8'h3C);

        // R5: two-edge latency
        wr(A_DIR, 8'h00);
        pin_i = 8'h00; edges(3);
        pin_i = 8'h5A; edges(1);
        rd(A_DAT, r); check("R5 after one edge", r, 8'h00);
        edges(1);
        rd(A_DAT, r); check("R5 after two edges", r, 8'h5A);

        // R6: unmapped offsets
        wr(A_DAT, 8'h11); wr(A_DIR, 8'h22);
        wr(8'h52, 8'hFF); wr(8'h00, 8'hFF);
        rd(8'h52, r); check("R6 unmapped read", r, 8'h00);
        rd(A_DIR, r); check("R6 dir untouched", r, 8'h22);
        wr(A_DIR, 8'hFF);
        rd(A_DAT, r); check("R6 data untouched", r, 8'h11);

        // R8: external bus beats dir and LCD
        wr(A_DIR, 8'h00);
        lcd_en = 1'b1; lcd_fp_en = 8'hFF; lcd_fp_val = 8'h00;
        ext_own = 7'h7F; ext_out = 7'h2B; #1;
        check("R8 ext oe", {1'b0, pin_oe[6:0]}, 8'h7F);
        check("R8 ext out", {1'b0, pin_o[6:0]}, 8'h2B);
        ext_own = '0; lcd_en = 1'b0; lcd_fp_en = '0;

        // R9: pin 7 control input
        wr(A_DIR, 8'h80); ctl_sel = 1'b1; pin_i = 8'h80; #1;
        check("R9 pin7 tristate", {7'd0, pin_oe[7]}, 8'h00);
        edges(2); #1;
        check("R9 ctl input", {7'd0, bus_ctl_in}, 8'h01);
        ctl_sel = 1'b0;

        // R10: LCD frontplane drive
        wr(A_DIR, 8'h00);
        lcd_en = 1'b1; lcd_fp_en = 8'hF0; lcd_fp_val = 8'hA0; #1;
        check("R10 fp oe", pin_oe, 8'hF0);
        check("R10 fp out", pin_o & 8'hF0, 8'hA0);

        // R11: backplane precedence on low nibble
        lcd_fp_en = 8'h0F; lcd_fp_val = 8'h09; lcd_bp_en = 1'b1; lcd_bp_val = 4'h6; #1;
        check("R11 bp oe", pin_oe, 8'h0F);
        check("R11 bp out", pin_o & 8'h0F, 8'h06);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule